// File: doc/BRIEF.md
# Interrupt Redirection Delivery Engine

This block keeps a request bit and a redirection entry for each of a bank of interrupt input pins, and turns requests that are pending and permitted into delivery messages. Each entry carries a vector, a delivery mode, a destination mode, a trigger mode, a mask and a destination, plus a remote-pending flag that the block maintains itself. The block is driven by the pin levels, by entry writes from an adjacent register file, and by end-of-interrupt broadcasts that carry a vector. It presents one message at a time on a valid/ready output.

Edge-mode pins latch a request on a rising input and drop it once it is delivered. Level-mode pins follow the input level. After a level-mode delivery the pin's remote-pending flag is set, and the pin is not delivered again until an end-of-interrupt with that pin's vector arrives. When an entry selects the external-interrupt delivery mode, the vector comes from a legacy controller through a request/acknowledge handshake. In every other mode the vector comes from the entry.

Top module: `irq_redirect_engine`

## Requirements
- R1: After reset every entry is masked, with its other fields zero and remote-pending clear. No request is pending, and both dlv_valid and ext_req are low.
- R2: When several pins are eligible together, the pin with the lowest index is delivered first. A pin is eligible when its request is set, it is unmasked, and it is not a level pin whose remote-pending flag is set.
- R3: A rising input on an unmasked edge-mode pin (entry bit 15 = 0) latches one request. That request yields exactly one delivery with trigger 0 and is cleared when the delivery is accepted.
- R4: A rising input on a masked pin (entry bit 16 = 1) in edge mode is discarded. Unmasking the pin later produces no delivery.
- R5: A level-mode pin (bit 15 = 1) delivers with trigger 1 and then sets its remote-pending flag. While the flag is set the pin is not delivered again, even if its input stays high.
- R6: A level-mode pin's request follows the input. If the input goes low before the pin is delivered, or before its remote-pending flag clears, no further delivery follows.
- R7: An end-of-interrupt clears remote-pending only on entries whose vector (bits 7:0) equals the broadcast vector. A pin whose request is still set and which is unmasked is then delivered again. A non-matching vector has no effect.
- R8: Input 0 raises pin 2, and input 2 also raises pin 2. Pin 0 never receives a request.
- R9: Delivery mode 3'b111 (bits 10:8) raises ext_req, which is held until ext_ack. The vector delivered is the ext_vector value present with ext_ack. dlv_valid stays low while ext_req is high.
- R10: A lower-half write (cfg_upper = 0) loads the vector (bits 7:0), the delivery mode (bits 10:8), the destination mode (bit 11), the trigger mode (bit 15) and the mask (bit 16). An upper-half write loads the destination from bits 31:24. Remote-pending is not writable. Unmasking a pin with a latched request delivers it.
- R11: The engine delivers at most one message per transfer. While dlv_valid is high and dlv_ready is low, the message stays valid with every field unchanged.
- R12: If a new rising edge arrives on an edge-mode pin in the same cycle its earlier delivery is accepted, the new request is kept and delivered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NPINS | Interrupt input levels |
| cfg_we | input | 1 | Entry write strobe |
| cfg_pin | input | PW | Pin whose entry is written |
| cfg_upper | input | 1 | 1 selects the upper half (destination), 0 the lower half |
| cfg_wdata | input | 32 | Write data for the selected half |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector carried by the broadcast |
| dlv_valid | output | 1 | Delivery message valid |
| dlv_ready | input | 1 | Delivery message accepted |
| dlv_dest | output | 8 | Destination |
| dlv_dest_mode | output | 1 | Destination mode |
| dlv_mode | output | 3 | Delivery mode |
| dlv_vector | output | 8 | Vector |
| dlv_trigger | output | 1 | Trigger mode, 1 = level |
| ext_req | output | 1 | Vector request to the legacy controller |
| ext_ack | input | 1 | Legacy controller acknowledge |
| ext_vector | input | 8 | Vector returned with the acknowledge |

## Verification
Two updates can land on the same request bit in one cycle: the clear that comes from accepting an edge-mode delivery, and the set that comes from a fresh rising edge on the same pin. The bench raises that pin's input in exactly the cycle it accepts the earlier message. It then expects a second delivery, which shows that the set outranks the clear. A held-off delivery is also combined with a new edge latched on another pin and a mask write to that pin. The bench checks that the held message stays unchanged, that the masked request stays silent, and that the request is delivered once the pin is unmasked.

// File: rtl/irq_redirect_engine.sv
module irq_redirect_engine #(
  parameter int NPINS = 24,
  localparam int PW = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] irq_in,
  input  logic             cfg_we,
  input  logic [PW-1:0]    cfg_pin,
  input  logic             cfg_upper,
  input  logic [31:0]      cfg_wdata,
  input  logic             eoi_valid,
  input  logic [7:0]       eoi_vector,
  output logic             dlv_valid,
  input  logic             dlv_ready,
  output logic [7:0]       dlv_dest,
  output logic             dlv_dest_mode,
  output logic [2:0]       dlv_mode,
  output logic [7:0]       dlv_vector,
  output logic             dlv_trigger,
  output logic             ext_req,
  input  logic             ext_ack,
  input  logic [7:0]       ext_vector
);

  localparam logic [2:0] MODE_EXT = 3'b111;

  typedef enum logic [1:0] {S_IDLE, S_EXT, S_OFFER} state_t;

  logic [NPINS-1:0] lvl, lvl_q, rise, irr, msk, trg, rirr, dstm, eligible;
  logic [7:0]       vec   [NPINS];
  logic [2:0]       dmode [NPINS];
  logic [7:0]       dest  [NPINS];

  state_t        state;
  logic [PW-1:0] sel_q, pick;
  logic          any, take;

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_map
      if (g == 0) begin : g_none
        assign lvl[g] = 1'b0;
      end else if (g == 2) begin : g_legacy
        assign lvl[g] = irq_in[2] | irq_in[0];
      end else begin : g_direct
        assign lvl[g] = irq_in[g];
      end
    end
  endgenerate

  assign rise     = lvl & ~lvl_q;
  assign eligible = irr & ~msk & ~(trg & rirr);
  assign any      = |eligible;
  assign take     = (state == S_OFFER) && dlv_ready;

  always_comb begin
    pick = '0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (eligible[i]) pick = PW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      irr   <= '0;
      rirr  <= '0;
      msk   <= '1;
      trg   <= '0;
      dstm  <= '0;
      for (int i = 0; i < NPINS; i++) begin
        vec[i]   <= '0;
        dmode[i] <= '0;
        dest[i]  <= '0;
      end
    end else begin
      lvl_q <= lvl;
      for (int i = 0; i < NPINS; i++) begin
        if (trg[i])
          irr[i] <= lvl[i];
        else
          irr[i] <= (irr[i] & ~(take && sel_q == PW'(i))) | (rise[i] & ~msk[i]);
        rirr[i] <= (take && sel_q == PW'(i) && dlv_trigger) |
                   (rirr[i] & ~(eoi_valid && vec[i] == eoi_vector));
        if (cfg_we && cfg_pin == PW'(i)) begin
          if (cfg_upper) begin
            dest[i] <= cfg_wdata[31:24];
          end else begin
            vec[i]   <= cfg_wdata[7:0];
            dmode[i] <= cfg_wdata[10:8];
            dstm[i]  <= cfg_wdata[11];
            trg[i]   <= cfg_wdata[15];
            msk[i]   <= cfg_wdata[16];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      sel_q         <= '0;
      dlv_dest      <= '0;
      dlv_dest_mode <= 1'b0;
      dlv_mode      <= '0;
      dlv_vector    <= '0;
      dlv_trigger   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (any) begin
          sel_q         <= pick;
          dlv_dest      <= dest[pick];
          dlv_dest_mode <= dstm[pick];
          dlv_mode      <= dmode[pick];
          dlv_vector    <= vec[pick];
          dlv_trigger   <= trg[pick];
          state         <= (dmode[pick] == MODE_EXT) ? S_EXT : S_OFFER;
        end
        S_EXT: if (ext_ack) begin
          dlv_vector <= ext_vector;
          state      <= S_OFFER;
        end
        S_OFFER: if (dlv_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign dlv_valid = (state == S_OFFER);
  assign ext_req   = (state == S_EXT);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !dlv_ready |=> dlv_valid &&
      $stable({dlv_dest, dlv_dest_mode, dlv_mode, dlv_vector, dlv_trigger}));

  assert_ext_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && !ext_ack |=> ext_req);

  assert_ext_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && ext_ack |=> dlv_valid && dlv_vector == $past(ext_vector));

  assert_masked_edge_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irr & ~trg & $past(rise & msk & ~trg & ~irr)) == '0));

  assert_level_remote_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && dlv_ready && dlv_trigger |=> rirr[$past(sel_q)]);

endmodule

// File: tb/irq_redirect_engine_test.sv
`timescale 1ns/1ps
module irq_redirect_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] irq_in = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_pin = '0;
  logic        cfg_upper = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;
  logic        dlv_ready = 1'b0;
  logic        ext_ack = 1'b0;
  logic [7:0]  ext_vector = '0;
  logic        dlv_valid, dlv_dest_mode, dlv_trigger, ext_req;
  logic [7:0]  dlv_dest, dlv_vector;
  logic [2:0]  dlv_mode;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_redirect_engine uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_pin(cfg_pin),
    .cfg_upper(cfg_upper), .cfg_wdata(cfg_wdata), .eoi_valid(eoi_valid),
    .eoi_vector(eoi_vector), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
    .dlv_dest(dlv_dest), .dlv_dest_mode(dlv_dest_mode), .dlv_mode(dlv_mode),
    .dlv_vector(dlv_vector), .dlv_trigger(dlv_trigger), .ext_req(ext_req),
    .ext_ack(ext_ack), .ext_vector(ext_vector));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int pin, input bit upper, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_pin = 5'(pin); cfg_upper = upper; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int pin);
    @(negedge clk); irq_in[pin] = 1'b1;
    @(negedge clk); irq_in[pin] = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  task automatic wait_valid(input string tag);
    for (int n = 0; n < 40; n++) begin
      if (dlv_valid) break;
      @(negedge clk);
    end
    chk(dlv_valid, tag, 32'(dlv_valid), 32'd1);
  endtask

  task automatic expect_dlv(input logic [7:0] v, input logic [7:0] d, input bit dm,
                            input logic [2:0] mode, input bit trig, input string tag);
    wait_valid(tag);
    chk(dlv_vector == v, tag, 32'(dlv_vector), 32'(v));
    chk({dlv_dest, dlv_dest_mode, dlv_mode, dlv_trigger} == {d, dm, mode, trig}, tag,
        32'({dlv_dest, dlv_dest_mode, dlv_mode, dlv_trigger}), 32'({d, dm, mode, trig}));
    dlv_ready = 1'b1;
    @(negedge clk);
    dlv_ready = 1'b0;
  endtask

  task automatic expect_none(input int n, input string tag);
    bit seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (dlv_valid || ext_req) seen = 1'b1;
    end
    chk(!seen, tag, 32'(seen), 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!dlv_valid && !ext_req, "R1 outputs idle after reset", 32'({dlv_valid, ext_req}), 32'd0);
    pulse(1);
    wr(1, 1'b0, 32'h0000_0031);
    expect_none(8, "R1 reset mask drops edge");
  endtask

  task automatic t_edge;
    wr(5, 1'b1, 32'h1200_0000);
    wr(5, 1'b0, 32'h0000_0035);
    pulse(5);
    expect_dlv(8'h35, 8'h12, 1'b0, 3'd0, 1'b0, "R3 R10 edge delivery");
    expect_none(8, "R3 single delivery per edge");
  endtask

  task automatic t_priority;
    wr(3, 1'b0, 32'h0000_0833);
    wr(9, 1'b0, 32'h0000_0039);
    @(negedge clk); irq_in[3] = 1'b1; irq_in[9] = 1'b1;
    @(negedge clk); irq_in[3] = 1'b0; irq_in[9] = 1'b0;
    expect_dlv(8'h33, 8'h00, 1'b1, 3'd0, 1'b0, "R2 lowest pin first");
    expect_dlv(8'h39, 8'h00, 1'b0, 3'd0, 1'b0, "R2 higher pin next");
    expect_none(6, "R2 nothing left");
  endtask

  task automatic t_masked_edge;
    wr(7, 1'b0, 32'h0001_0047);
    pulse(7);
    expect_none(4, "R4 masked edge silent");
    wr(7, 1'b0, 32'h0000_0047);
    expect_none(8, "R4 masked edge discarded");
  endtask

  task automatic t_hold_and_unmask;
    wr(4, 1'b0, 32'h0000_0044);
    wr(8, 1'b0, 32'h0000_0048);
    pulse(4);
    wait_valid("R11 offer");
    chk(dlv_vector == 8'h44, "R11 held vector", 32'(dlv_vector), 32'h44);
    pulse(8);
    wr(8, 1'b0, 32'h0001_0048);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(dlv_valid && dlv_vector == 8'h44, "R11 stable while not ready",
          32'({dlv_valid, dlv_vector}), 32'h144);
    end
    dlv_ready = 1'b1;
    @(negedge clk);
    dlv_ready = 1'b0;
    expect_none(8, "R10 masked latched request waits");
    wr(8, 1'b0, 32'h0000_0048);
    expect_dlv(8'h48, 8'h00, 1'b0, 3'd0, 1'b0, "R10 unmask delivers latched request");
  endtask

  task automatic t_level;
    wr(10, 1'b0, 32'h0000_805A);
    @(negedge clk); irq_in[10] = 1'b1;
    expect_dlv(8'h5A, 8'h00, 1'b0, 3'd0, 1'b1, "R5 level delivery");
    expect_none(10, "R5 remote flag blocks redelivery");
    eoi(8'h11);
    expect_none(6, "R7 non-matching eoi ignored");
    eoi(8'h5A);
    expect_dlv(8'h5A, 8'h00, 1'b0, 3'd0, 1'b1, "R7 matching eoi redelivers");
    @(negedge clk); irq_in[10] = 1'b0;
    repeat (2) @(negedge clk);
    eoi(8'h5A);
    expect_none(8, "R6 low level leaves nothing pending");
  endtask

  task automatic t_level_low;
    wr(11, 1'b0, 32'h0001_805B);
    @(negedge clk); irq_in[11] = 1'b1;
    expect_none(4, "R6 masked level silent");
    irq_in[11] = 1'b0;
    repeat (3) @(negedge clk);
    wr(11, 1'b0, 32'h0000_805B);
    expect_none(8, "R6 dropped level cleared request");
  endtask

  task automatic t_ext;
    wr(6, 1'b0, 32'h0000_0766);
    pulse(6);
    for (int n = 0; n < 20 && !ext_req; n++) @(negedge clk);
    chk(ext_req && !dlv_valid, "R9 request raised", 32'({ext_req, dlv_valid}), 32'h2);
    repeat (3) @(negedge clk);
    chk(ext_req && !dlv_valid, "R9 request held", 32'({ext_req, dlv_valid}), 32'h2);
    ext_ack = 1'b1; ext_vector = 8'hA7;
    @(negedge clk);
    ext_ack = 1'b0; ext_vector = 8'h00;
    expect_dlv(8'hA7, 8'h00, 1'b0, 3'd7, 1'b0, "R9 external vector");
  endtask

  task automatic t_legacy;
    wr(0, 1'b0, 32'h0000_0020);
    wr(2, 1'b0, 32'h0000_0022);
    pulse(0);
    expect_dlv(8'h22, 8'h00, 1'b0, 3'd0, 1'b0, "R8 input 0 to pin 2");
    expect_none(8, "R8 pin 0 never requested");
    pulse(2);
    expect_dlv(8'h22, 8'h00, 1'b0, 3'd0, 1'b0, "R8 input 2 to pin 2");
  endtask

  task automatic t_collision;
    wr(12, 1'b0, 32'h0000_006C);
    pulse(12);
    wait_valid("R12 first offer");
    dlv_ready = 1'b1; irq_in[12] = 1'b1;
    @(negedge clk);
    dlv_ready = 1'b0; irq_in[12] = 1'b0;
    expect_dlv(8'h6C, 8'h00, 1'b0, 3'd0, 1'b0, "R12 edge in accept cycle kept");
    expect_none(8, "R12 no third delivery");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_edge();
    t_priority();
    t_masked_edge();
    t_hold_and_unmask();
    t_level();
    t_level_low();
    t_ext();
    t_legacy();
    t_collision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule